// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is a synchronous model of a byte-wide serial memory that sits on an I2C bus as a slave. It runs on a system clock and oversamples SCL and SDA through two-stage synchronisers. It drives SDA only through an open-drain enable: when `sda_oe` is high the pad pulls the line low, and when it is low the line is released. Every transaction opens with a Start. Next comes a device select byte. Its upper nibble is a fixed type code, bits [3:1] carry either chip-enable bits or upper memory address bits depending on density, and bit 0 selects read (1) or write (0).

After a write select, the next byte loads the low part of an internal address pointer. Each byte after that is stored at the pointer, which then advances. After a read select, the slave returns bytes MSB first from the pointer. It keeps sending as long as the master acknowledges each one. A not-acknowledge from the master ends the read. Two inputs gate operation. A write-control input blocks stores. A power-on hold input makes the slave deaf to the bus.

The `MEM_BYTES` parameter (128, 256, 512, 1024 or 2048) sets the depth. It also sets how many select bits are compared against the chip-enable pins and how many carry address bits.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_oe` is low and the slave stays idle until a Start (SDA falling while SCL is high).
- R2: The slave acknowledges a select byte only when its bits [7:4] equal 4'b1010; any other code gets no acknowledge and the transfer is ignored until the next Start or Stop.
- R3: Select bits [3:1] line up with chip-enable inputs chip_en[2:0] (bit 3 with chip_en[2]). The lowest log2(MEM_BYTES)-8 of these positions, when that count is positive, hold memory address bits A8 and up, starting at bit 1. Those positions are not compared. Every remaining position must equal its chip-enable input. With 1024 bytes only bit 3 is compared, against chip_en[2].
- R4: The slave acknowledges a matching select byte, the word address byte and each accepted data byte by pulling SDA low during the 9th SCL clock.
- R5: In a write, the word address byte sets pointer bits [7:0] and the select byte sets the upper bits. Each acknowledged data byte is stored at the pointer, and the pointer then increments.
- R6: In a read, the slave shifts out the byte at the pointer MSB first, one bit per SCL clock, then releases SDA for the 9th clock and increments the pointer. A master acknowledge yields the next byte. A not-acknowledge ends the read with SDA released.
- R7: The pointer wraps from MEM_BYTES-1 to 0 on both writes and reads.
- R8: While `wr_ctrl` is high, data bytes get no acknowledge and memory and pointer are unchanged. Select and address bytes are still acknowledged.
- R9: While `por_hold` is high, the slave ignores all bus activity, never drives SDA and stores nothing.
- R10: A Stop returns the slave to idle, so that a following byte without a Start gets no acknowledge. A repeated Start returns it to select matching while keeping the pointer, which permits a random read.
- R11: `sda_oe` only rises while SCL is low, and a Stop releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND bus) |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA |
| chip_en | input | 3 | Chip-enable strap inputs |
| wr_ctrl | input | 1 | Write control; high blocks data stores |
| por_hold | input | 1 | Power-on lockout; high makes the slave deaf |

## Verification
The hardest case to reach is the wrap at the top of memory. It is only visible when the pointer sits at the last location, and that location needs the upper address bits carried in the select byte. The bench therefore writes two bytes starting at the final address, using a select byte whose address positions are set. It then reads back across the same boundary after a repeated Start. The chip-enable corner is reached by changing the strap inputs between transfers. Changing them shows that the compared position gates the acknowledge and that the positions used for address bits are ignored.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_WR,
    ST_RD,
    ST_SKIP
  } ee_state_e;

  function automatic int addr_bits(input int bytes);
    return $clog2(bytes);
  endfunction

  function automatic int page_bits(input int bytes);
    int a;
    a = $clog2(bytes);
    return (a > 8) ? a - 8 : 0;
  endfunction
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr   <= '1;
      sda_sr   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sr   <= {scl_sr[STAGES-2:0], scl_in};
      sda_sr   <= {sda_sr[STAGES-2:0], sda_in};
      scl_prev <= scl_sr[STAGES-1];
      sda_prev <= sda_sr[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sr[STAGES-1];
  assign sda_lvl   = sda_sr[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  // SDA edges while SCL held high on both samples are bus conditions
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
  import i2c_ee_pkg::*;
#(
  parameter int AW     = 10,
  parameter int PAGE_W = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          por_hold,
  input  logic          wr_ctrl,
  input  logic [2:0]    chip_en,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [7:0]    mem_q,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] ptr,
  output logic          sda_oe
);
  localparam logic [10:0] PAGE_MASK = 11'(((1 << PAGE_W) - 1) << 8);

  ee_state_e  state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic [7:0] tx;
  logic       cont;
  logic [2:0] ce_ok;
  logic       sel_hit;
  logic [10:0] wide_ptr, sel_wide, addr_wide;
  logic [2:0] bidx;

  for (genvar i = 0; i < 3; i++) begin : g_ce
    if (i < PAGE_W) begin : g_addr_pos
      assign ce_ok[i] = 1'b1;
    end else begin : g_cmp_pos
      assign ce_ok[i] = (shreg[i+1] == chip_en[i]);
    end
  end

  always_comb begin
    sel_hit   = (shreg[7:4] == DEV_TYPE) && (&ce_ok);
    wide_ptr  = 11'(ptr);
    sel_wide  = (wide_ptr & ~PAGE_MASK) | ({shreg[3:1], 8'h00} & PAGE_MASK);
    addr_wide = (wide_ptr & ~11'h0FF) | {3'b000, shreg};
    bidx      = 3'(4'd7 - cnt);
  end

  logic unused_bits;
  assign unused_bits = ^{chip_en, sel_wide, addr_wide};

  always_ff @(posedge clk) begin
    mem_we <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      tx        <= '0;
      cont      <= 1'b0;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else if (por_hold) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_SEL;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (cnt < 4'd8) shreg <= {shreg[6:0], sda_lvl};
        else if (state == ST_RD) cont <= ~sda_lvl;
        if (cnt != 4'd9) cnt <= cnt + 4'd1;
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          unique case (state)
            ST_SEL: begin
              if (sel_hit) begin
                sda_oe <= 1'b1;
                ptr    <= sel_wide[AW-1:0];
                state  <= shreg[0] ? ST_RD : ST_ADDR;
              end else begin
                state  <= ST_SKIP;
              end
            end
            ST_ADDR: begin
              sda_oe <= 1'b1;
              ptr    <= addr_wide[AW-1:0];
              state  <= ST_WR;
            end
            ST_WR: begin
              if (!wr_ctrl) begin
                sda_oe    <= 1'b1;
                mem_we    <= 1'b1;
                mem_waddr <= ptr;
                mem_wdata <= shreg;
                ptr       <= ptr + AW'(1);
              end
            end
            ST_RD: begin
              sda_oe <= 1'b0;
              ptr    <= ptr + AW'(1);
            end
            default: ;
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          if (state == ST_RD) begin
            if (cont) begin
              tx     <= mem_q;
              sda_oe <= ~mem_q[7];
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_SKIP;
            end
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (state == ST_RD && cnt != 4'd0) begin
          sda_oe <= ~tx[bidx];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [2:0] chip_en,
  input  logic       wr_ctrl,
  input  logic       por_hold
);
  localparam int AW     = addr_bits(MEM_BYTES);
  localparam int PAGE_W = page_bits(MEM_BYTES);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic mem_we;
  logic [AW-1:0] mem_waddr, ptr;
  logic [7:0] mem_wdata, mem_q;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_ee_ctrl #(.AW(AW), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst(rst), .por_hold(por_hold), .wr_ctrl(wr_ctrl),
    .chip_en(chip_en), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .mem_q(mem_q), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .ptr(ptr), .sda_oe(sda_oe)
  );

  i2c_ee_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(mem_q)
  );
endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker (
  input logic clk,
  input logic rst,
  input logic por_hold,
  input logic wr_ctrl,
  input logic sda_oe,
  input logic scl_lvl,
  input logic stop_evt,
  input logic mem_we
);
  // R11: pull-down only starts while synchronised SCL is low
  a_r11_oe_rise_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_lvl));

  // R11 / R10: a Stop frees the line
  a_r10_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);

  // R9: lockout keeps the line released
  a_r9_por_quiet: assert property (@(posedge clk) disable iff (rst)
    por_hold |=> !sda_oe);

  // R9: lockout blocks stores
  a_r9_por_no_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(por_hold));

  // R8: write control blocks stores
  a_r8_wc_no_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(wr_ctrl));
endmodule

bind i2c_eeprom_slave i2c_ee_checker u_chk (
  .clk(clk), .rst(rst), .por_hold(por_hold), .wr_ctrl(wr_ctrl),
  .sda_oe(sda_oe), .scl_lvl(scl_lvl), .stop_evt(stop_evt), .mem_we(mem_we)
);

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] chip_en = 3'b100;
  logic wr_ctrl = 1'b0;
  logic por_hold = 1'b0;
  logic sda_oe;
  logic sda_line;
  int tests = 0;
  int fails = 0;
  int oe_bad = 0;
  logic prev_oe = 1'b0;

  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_eeprom_slave u_i2c_eeprom_slave (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .chip_en(chip_en), .wr_ctrl(wr_ctrl), .por_hold(por_hold)
  );

  // R11 port monitor: a new pull-down must not appear while SCL is high
  always @(negedge clk) begin
    if (!rst && sda_oe && !prev_oe && m_scl) oe_bad++;
    prev_oe <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  function automatic logic [7:0] sel(input bit e2, input logic [1:0] hi, input bit rd);
    return {4'hA, e2, hi, rd};
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1);
    m_sda = 1'b0; qw(1); m_scl = 1'b0; qw(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw(1); m_scl = 1'b1; qw(1); m_sda = 1'b1; qw(1);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qw(1); m_scl = 1'b1; qw(2); m_scl = 1'b0; qw(1);
    end
    m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1);
    ack = (sda_line == 1'b0);
    qw(1); m_scl = 1'b0; qw(1);
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(1); m_scl = 1'b1; qw(1); b[i] = sda_line; qw(1); m_scl = 1'b0;
    end
    qw(1); m_sda = ~mack; qw(1); m_scl = 1'b1; qw(2); m_scl = 1'b0; qw(1);
    m_sda = 1'b1;
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 reset oe", int'(sda_oe), 0);
  endtask

  task automatic t_write_seq();
    bit a;
    bus_start();
    wbyte(sel(1'b1, 2'b01, 1'b0), a); check(a, "R4 select ack", a, 1);
    wbyte(8'h10, a); check(a, "R4 address ack", a, 1);
    wbyte(8'h5A, a); check(a, "R5 data0 ack", a, 1);
    wbyte(8'hC3, a); check(a, "R5 data1 ack", a, 1);
    wbyte(8'h01, a); check(a, "R5 data2 ack", a, 1);
    bus_stop();
  endtask

  task automatic t_random_read();
    bit a;
    logic [7:0] d;
    bus_start();
    wbyte(sel(1'b1, 2'b01, 1'b0), a);
    wbyte(8'h10, a);
    bus_start();
    wbyte(sel(1'b1, 2'b01, 1'b1), a); check(a, "R10 repeated start select", a, 1);
    rbyte(1'b1, d); check(d == 8'h5A, "R6 read byte0", d, 8'h5A);
    rbyte(1'b1, d); check(d == 8'hC3, "R6 read byte1", d, 8'hC3);
    rbyte(1'b0, d); check(d == 8'h01, "R6 read byte2", d, 8'h01);
    qw(1);
    check(sda_oe == 1'b0, "R6 release after nack", int'(sda_oe), 0);
    bus_stop();
  endtask

  task automatic t_bad_type();
    bit a;
    bus_start();
    wbyte({4'hB, 1'b1, 2'b01, 1'b0}, a); check(!a, "R2 wrong type code", a, 0);
    bus_stop();
  endtask

  task automatic t_chip_enable();
    bit a;
    bus_start();
    wbyte(sel(1'b0, 2'b01, 1'b0), a); check(!a, "R3 E2 mismatch", a, 0);
    bus_stop();
    chip_en = 3'b011;
    bus_start();
    wbyte(sel(1'b0, 2'b10, 1'b0), a); check(a, "R3 address positions ignored", a, 1);
    bus_stop();
    chip_en = 3'b100;
  endtask

  task automatic t_wrap();
    bit a;
    logic [7:0] d;
    bus_start();
    wbyte(sel(1'b1, 2'b11, 1'b0), a);
    wbyte(8'hFF, a);
    wbyte(8'h77, a);
    wbyte(8'h99, a); check(a, "R7 write across top", a, 1);
    bus_stop();
    bus_start();
    wbyte(sel(1'b1, 2'b00, 1'b0), a);
    wbyte(8'h00, a);
    bus_start();
    wbyte(sel(1'b1, 2'b00, 1'b1), a);
    rbyte(1'b0, d); check(d == 8'h99, "R7 wrapped write landed at 0", d, 8'h99);
    bus_stop();
    bus_start();
    wbyte(sel(1'b1, 2'b11, 1'b0), a);
    wbyte(8'hFF, a);
    bus_start();
    wbyte(sel(1'b1, 2'b11, 1'b1), a);
    rbyte(1'b1, d); check(d == 8'h77, "R7 top byte", d, 8'h77);
    rbyte(1'b0, d); check(d == 8'h99, "R7 read wraps to 0", d, 8'h99);
    bus_stop();
  endtask

  task automatic t_write_ctrl();
    bit a;
    logic [7:0] d;
    wr_ctrl = 1'b1;
    bus_start();
    wbyte(sel(1'b1, 2'b01, 1'b0), a); check(a, "R8 select acked under WC", a, 1);
    wbyte(8'h10, a); check(a, "R8 address acked under WC", a, 1);
    wbyte(8'hEE, a); check(!a, "R8 data not acked", a, 0);
    bus_stop();
    wr_ctrl = 1'b0;
    bus_start();
    wbyte(sel(1'b1, 2'b01, 1'b0), a);
    wbyte(8'h10, a);
    bus_start();
    wbyte(sel(1'b1, 2'b01, 1'b1), a);
    rbyte(1'b0, d); check(d == 8'h5A, "R8 memory unchanged", d, 8'h5A);
    bus_stop();
  endtask

  task automatic t_por();
    bit a;
    logic [7:0] d;
    por_hold = 1'b1;
    bus_start();
    wbyte(sel(1'b1, 2'b01, 1'b0), a); check(!a, "R9 no ack in lockout", a, 0);
    wbyte(8'h11, a);
    wbyte(8'h22, a); check(!a, "R9 data ignored in lockout", a, 0);
    bus_stop();
    por_hold = 1'b0;
    bus_start();
    wbyte(sel(1'b1, 2'b01, 1'b0), a); check(a, "R9 responds after release", a, 1);
    wbyte(8'h11, a);
    bus_start();
    wbyte(sel(1'b1, 2'b01, 1'b1), a);
    rbyte(1'b0, d); check(d == 8'hC3, "R9 memory untouched", d, 8'hC3);
    bus_stop();
  endtask

  task automatic t_stop_idle();
    bit a;
    bus_start();
    wbyte(sel(1'b1, 2'b01, 1'b0), a);
    bus_stop();
    m_scl = 1'b0; qw(1);
    wbyte(8'h10, a); check(!a, "R10 idle after stop", a, 0);
    m_scl = 1'b1; qw(1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_seq();
    t_random_read();
    t_bad_type();
    t_chip_enable();
    t_wrap();
    t_write_ctrl();
    t_por();
    t_stop_idle();
    check(oe_bad == 0, "R11 oe rose with SCL high", oe_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule